// File: doc/BRIEF.md
# Configuration Access Conflict Monitor

This block sits beside the configuration bus of an image-processing pipeline and watches host accesses to the pipeline's internal storage: line buffers, lookup tables, a lens-shading table, the registers and statistics memory of a contrast-enhancement stage, color and contrast tables, and a histogram memory. An access that falls inside a timing window in which the pixel datapath owns that storage is a conflict. Each storage class has its own rule, and each rule has a sticky status bit.

Frame, line and contrast-enhancement windows are tracked from single-cycle timing strobes that share the block's clock. Software clears status bits by writing ones to a control word, and it selects which bits drive the interrupt line through a mask word on the same bus. The monitor also flags a histogram readout that began but did not finish before the next frame started.

The address is split into a 4-bit region (upper bits) and an offset (lower bits). The monitor only observes accesses. The storage itself answers them.

Top module: `cfg_conflict_mon`

## Requirements
- R1: After reset, every status bit is 0, the mask is all ones, and irq is 0.
- R2: Region 0 (line buffer) sets status bit 0 on a read while the line window is open, or on a write while the frame window is open. A read in the frame but outside a line sets nothing.
- R3: Region 1 (table) sets status bit 1 on any read or write while the frame window is open.
- R4: Region 2 (lens table) sets status bit 2 on any access from the vertical-start cycle through the cycle after the vertical-end strobe.
- R5: Region 3 (enhancement registers) sets status bit 3 on a write from the vertical-start cycle through the filter-done cycle. Reads never set it.
- R6: Region 4 (enhancement statistics) sets status bit 4 on any access in that same vertical-start to filter-done window.
- R7: Regions 5 (color table) and 6 (contrast table) set status bits 5 and 6 on any access while the line window is open, and only while the matching enable input is 1.
- R8: Region 7 is the histogram. On a vertical-start, status bit 7 is set if offset 0 was read since the previous vertical-start and offset HIST_DEPTH-1 was not. Tracking then restarts, using the reads of that vertical-start cycle.
- R9: Accesses to regions 8 to 14 never set any status bit.
- R10: A write to region 15 offset 0 clears each status bit whose data bit is 1. Data bits of 0 have no effect. A bit that is set and cleared in the same cycle ends up set.
- R11: A write to region 15 offset 1 loads the mask from the data. irq is the OR of all status bits ANDed with the mask.
- R12: The frame window is open from the vertical-start cycle through the vertical-end cycle. The line window is open from the line-start cycle through the line-end cycle. A status bit changes on the clock edge that ends the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vs_in | input | 1 | Vertical-start strobe |
| ve_in | input | 1 | Vertical-end strobe |
| ls_in | input | 1 | Line-start strobe |
| le_in | input | 1 | Line-end strobe |
| filt_done | input | 1 | Contrast-enhancement filter-done pulse |
| color_lut_en | input | 1 | Color table enabled |
| contrast_lut_en | input | 1 | Contrast table enabled |
| cfg_sel | input | 1 | Configuration bus select |
| cfg_rd | input | 1 | Read access |
| cfg_wr | input | 1 | Write access |
| cfg_addr | input | ADDR_W | Access address, region in top 4 bits |
| cfg_wdata | input | DATA_W | Write data, low 8 bits used |
| err_status | output | 8 | Sticky conflict status bits |
| irq | output | 1 | Masked OR of status |

## Verification
The assertions assume that every timing strobe is a single-cycle pulse on the block's clock. They also assume that read and write are never both asserted while select is high. The bench drives each strobe for exactly one cycle and issues bus accesses one cycle at a time, each either a read or a write. The histogram incomplete-read rule is checked by placing clear writes in the same cycle as a vertical-start, which is the only cycle in which a new set and a clear can meet.

// File: rtl/cfgmon_pkg.sv
// Shared constants for the configuration conflict monitor.
// Assumes: region codes sit in the top four address bits.
package cfgmon_pkg;
    localparam int NUM_ERR = 8;

    localparam logic [3:0] RG_LINE   = 4'd0;
    localparam logic [3:0] RG_TABLE  = 4'd1;
    localparam logic [3:0] RG_LENS   = 4'd2;
    localparam logic [3:0] RG_CEREG  = 4'd3;
    localparam logic [3:0] RG_CESTAT = 4'd4;
    localparam logic [3:0] RG_COLOR  = 4'd5;
    localparam logic [3:0] RG_CONTR  = 4'd6;
    localparam logic [3:0] RG_HIST   = 4'd7;
    localparam logic [3:0] RG_CTRL   = 4'd15;

    localparam int B_LINE   = 0;
    localparam int B_TABLE  = 1;
    localparam int B_LENS   = 2;
    localparam int B_CEREG  = 3;
    localparam int B_CESTAT = 4;
    localparam int B_COLOR  = 5;
    localparam int B_CONTR  = 6;
    localparam int B_HIST   = 7;
endpackage

// File: rtl/cfgmon_timing.sv
// Window tracker: derives the frame, line, lens and enhancement windows
// from single-cycle strobes. Each window includes its opening strobe cycle.
// Assumes: all strobes are synchronous one-cycle pulses.
module cfgmon_timing (
    input  logic clk,
    input  logic rst_n,
    input  logic vs,
    input  logic ve,
    input  logic ls,
    input  logic le,
    input  logic done,
    output logic frame_win,
    output logic line_win,
    output logic lens_win,
    output logic ce_win
);
    logic frame_q, line_q, ce_q, ve_d1;

    // Track the frame, line and enhancement active flags plus a delayed end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            line_q  <= 1'b0;
            ce_q    <= 1'b0;
            ve_d1   <= 1'b0;
        end else begin
            frame_q <= vs ? 1'b1 : (ve ? 1'b0 : frame_q);
            line_q  <= ls ? 1'b1 : (le ? 1'b0 : line_q);
            ce_q    <= vs ? 1'b1 : (done ? 1'b0 : ce_q);
            ve_d1   <= ve;
        end
    end

    // Open each window in the cycle of its start strobe.
    always_comb begin
        frame_win = frame_q | vs;
        line_win  = line_q | ls;
        ce_win    = ce_q | vs;
        lens_win  = frame_win | ve_d1;
    end

    // R12
    vs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs |=> frame_q);
    // R12
    ve_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ve && !vs) |=> !frame_q);
    // R12
    le_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le && !ls) |=> !line_q);
    // R5
    done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !vs) |=> !ce_q);
endmodule

// File: rtl/cfgmon_decode.sv
// Rule evaluator: decodes the access region and applies the conflict rule
// of that region against the current windows. It also produces the control
// word strobes and the histogram first/last read hits.
// Assumes: read and write are never both asserted together.
module cfgmon_decode
    import cfgmon_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int HIST_DEPTH = 256
) (
    input  logic               sel,
    input  logic               rd,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               frame_win,
    input  logic               line_win,
    input  logic               lens_win,
    input  logic               ce_win,
    input  logic               color_en,
    input  logic               contr_en,
    output logic [NUM_ERR-1:0] acc_set,
    output logic [NUM_ERR-1:0] clr_vec,
    output logic               mask_wr,
    output logic [NUM_ERR-1:0] mask_data,
    output logic               hist_first,
    output logic               hist_last
);
    localparam int OFS_W = ADDR_W - 4;
    localparam logic [OFS_W-1:0] HIST_LAST = OFS_W'(HIST_DEPTH - 1);

    logic             acc;
    logic [3:0]       region;
    logic [OFS_W-1:0] ofs;

    // Split the address and qualify the access.
    always_comb begin
        acc    = sel & (rd | wr);
        region = addr[ADDR_W-1 -: 4];
        ofs    = addr[OFS_W-1:0];
    end

    // Apply the per-region conflict rule.
    always_comb begin
        acc_set = '0;
        if (acc) begin
            case (region)
                RG_LINE:   acc_set[B_LINE]   = (rd & line_win) | (wr & frame_win);
                RG_TABLE:  acc_set[B_TABLE]  = frame_win;
                RG_LENS:   acc_set[B_LENS]   = lens_win;
                RG_CEREG:  acc_set[B_CEREG]  = wr & ce_win;
                RG_CESTAT: acc_set[B_CESTAT] = ce_win;
                RG_COLOR:  acc_set[B_COLOR]  = line_win & color_en;
                RG_CONTR:  acc_set[B_CONTR]  = line_win & contr_en;
                default:   acc_set = '0;
            endcase
        end
    end

    // Decode control-word writes and histogram read hits.
    always_comb begin
        clr_vec    = (acc && wr && region == RG_CTRL && ofs == OFS_W'(0))
                     ? wdata[NUM_ERR-1:0] : '0;
        mask_wr    = acc && wr && region == RG_CTRL && ofs == OFS_W'(1);
        mask_data  = wdata[NUM_ERR-1:0];
        hist_first = acc && rd && region == RG_HIST && ofs == OFS_W'(0);
        hist_last  = acc && rd && region == RG_HIST && ofs == HIST_LAST;
    end

    initial begin
        assert (HIST_DEPTH >= 2 && HIST_DEPTH <= (1 << OFS_W));
        assert (DATA_W >= NUM_ERR);
    end
endmodule

// File: rtl/cfgmon_hist.sv
// Histogram readout tracker: remembers whether the first and the last
// location were read since the last vertical-start, and flags an
// incomplete readout when the next vertical-start arrives.
// Assumes: vs is a one-cycle pulse.
module cfgmon_hist (
    input  logic clk,
    input  logic rst_n,
    input  logic vs,
    input  logic first_rd,
    input  logic last_rd,
    output logic hist_err
);
    logic first_q, last_q;

    // Evaluate the incomplete-read condition at frame start.
    always_comb hist_err = vs & first_q & ~last_q;

    // Accumulate read hits and restart tracking at each vertical-start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (vs) begin
            first_q <= first_rd;
            last_q  <= last_rd;
        end else begin
            first_q <= first_q | first_rd;
            last_q  <= last_q | last_rd;
        end
    end

    // R8
    first_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_rd |=> first_q);
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs && !first_rd) |=> !first_q);
endmodule

// File: rtl/cfgmon_status.sv
// Sticky status and mask: sets bits from detected conflicts, clears them on
// write-one, lets a set win over a clear, and drives the masked interrupt.
// Assumes: set and clear vectors are valid for one cycle each.
module cfgmon_status
    import cfgmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] set_vec,
    input  logic [NUM_ERR-1:0] clr_vec,
    input  logic               mask_wr,
    input  logic [NUM_ERR-1:0] mask_data,
    output logic [NUM_ERR-1:0] status,
    output logic               irq
);
    logic [NUM_ERR-1:0] status_q, mask_q;

    // Update each status bit: clear by write-one, then set with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
        end
    end

    // Hold the interrupt mask, loaded by its control word.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= mask_data;
    end

    // Reduce the masked status to the interrupt line.
    always_comb begin
        status = status_q;
        irq    = |(status_q & mask_q);
    end

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~clr_vec) != '0) |=>
        ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
    // R11
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((set_vec & mask_q) != '0) && !mask_wr) |=> irq);
endmodule

// File: rtl/cfg_conflict_mon.sv
// Configuration access conflict monitor top: ties the window tracker, the
// rule evaluator, the histogram tracker and the status register together.
// Assumes: single clock, synchronous strobes, one bus access per cycle.
module cfg_conflict_mon
    import cfgmon_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int HIST_DEPTH = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vs_in,
    input  logic               ve_in,
    input  logic               ls_in,
    input  logic               le_in,
    input  logic               filt_done,
    input  logic               color_lut_en,
    input  logic               contrast_lut_en,
    input  logic               cfg_sel,
    input  logic               cfg_rd,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [NUM_ERR-1:0] err_status,
    output logic               irq
);
    logic frame_win, line_win, lens_win, ce_win;
    logic [NUM_ERR-1:0] acc_set, clr_vec, mask_data, set_vec;
    logic mask_wr, hist_first, hist_last, hist_err;

    cfgmon_timing u_timing (
        .clk(clk), .rst_n(rst_n), .vs(vs_in), .ve(ve_in), .ls(ls_in),
        .le(le_in), .done(filt_done), .frame_win(frame_win),
        .line_win(line_win), .lens_win(lens_win), .ce_win(ce_win)
    );

    cfgmon_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIST_DEPTH(HIST_DEPTH)) u_decode (
        .sel(cfg_sel), .rd(cfg_rd), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .frame_win(frame_win), .line_win(line_win), .lens_win(lens_win),
        .ce_win(ce_win), .color_en(color_lut_en), .contr_en(contrast_lut_en),
        .acc_set(acc_set), .clr_vec(clr_vec), .mask_wr(mask_wr),
        .mask_data(mask_data), .hist_first(hist_first), .hist_last(hist_last)
    );

    cfgmon_hist u_hist (
        .clk(clk), .rst_n(rst_n), .vs(vs_in), .first_rd(hist_first),
        .last_rd(hist_last), .hist_err(hist_err)
    );

    // Merge per-access conflicts with the frame-start histogram check.
    always_comb begin
        set_vec         = acc_set;
        set_vec[B_HIST] = hist_err;
    end

    cfgmon_status u_status (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .mask_wr(mask_wr), .mask_data(mask_data), .status(err_status), .irq(irq)
    );

    // R9
    quiet_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_addr[ADDR_W-1 -: 4] >= 4'd8 && cfg_addr[ADDR_W-1 -: 4] != 4'd15
         && !vs_in && clr_vec == '0) |=> $stable(err_status));
endmodule

// File: tb/sim_cfg_conflict_mon.sv
module sim_cfg_conflict_mon;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vs_in = 0, ve_in = 0, ls_in = 0, le_in = 0, filt_done = 0;
    logic color_lut_en = 0, contrast_lut_en = 0;
    logic cfg_sel = 0, cfg_rd = 0, cfg_wr = 0;
    logic [11:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  err_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    cfg_conflict_mon u0 (
        .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .ve_in(ve_in), .ls_in(ls_in),
        .le_in(le_in), .filt_done(filt_done), .color_lut_en(color_lut_en),
        .contrast_lut_en(contrast_lut_en), .cfg_sel(cfg_sel), .cfg_rd(cfg_rd),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .err_status(err_status), .irq(irq)
    );

    // Behavioural reference model, evaluated on each rising edge.
    bit m_frame, m_line, m_ce, m_ved, m_first, m_last;
    bit [7:0] m_status, m_mask, setv, clr;
    bit acc, fw, lw, cw, lensw, hf, hl;
    int rg, ofs;

    always @(posedge clk) begin
        rg  = int'(cfg_addr[11:8]);
        ofs = int'(cfg_addr[7:0]);
        acc = cfg_sel && (cfg_rd || cfg_wr);
        if (!rst_n) begin
            m_frame = 0; m_line = 0; m_ce = 0; m_ved = 0; m_first = 0; m_last = 0;
            m_status = 0; m_mask = 8'hFF;
        end else begin
            fw = m_frame || vs_in; lw = m_line || ls_in; cw = m_ce || vs_in;
            lensw = fw || m_ved;
            setv = 0;
            if (acc) begin
                if (rg == 0 && ((cfg_rd && lw) || (cfg_wr && fw))) setv[0] = 1;
                if (rg == 1 && fw) setv[1] = 1;
                if (rg == 2 && lensw) setv[2] = 1;
                if (rg == 3 && cfg_wr && cw) setv[3] = 1;
                if (rg == 4 && cw) setv[4] = 1;
                if (rg == 5 && lw && color_lut_en) setv[5] = 1;
                if (rg == 6 && lw && contrast_lut_en) setv[6] = 1;
            end
            hf = acc && cfg_rd && rg == 7 && ofs == 0;
            hl = acc && cfg_rd && rg == 7 && ofs == 255;
            if (vs_in) begin
                if (m_first && !m_last) setv[7] = 1;
                m_first = hf; m_last = hl;
            end else begin
                m_first = m_first || hf; m_last = m_last || hl;
            end
            clr = (acc && cfg_wr && rg == 15 && ofs == 0) ? cfg_wdata[7:0] : 8'h00;
            if (acc && cfg_wr && rg == 15 && ofs == 1) m_mask = cfg_wdata[7:0];
            m_status = (m_status & ~clr) | setv;
            m_frame = vs_in ? 1 : (ve_in ? 0 : m_frame);
            m_line  = ls_in ? 1 : (le_in ? 0 : m_line);
            m_ce    = vs_in ? 1 : (filt_done ? 0 : m_ce);
            m_ved   = ve_in;
        end
        #1;
        if (!done_flag) begin
            checks++;
            if (err_status !== m_status || irq !== |(m_status & m_mask)) begin
                errors++;
                $display("FAIL R12 model compare: status %h irq %b, expected %h irq %b",
                         err_status, irq, m_status, |(m_status & m_mask));
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle: strobes {vs,ve,ls,le,done}, then a bus access.
    task automatic tick(input logic [4:0] s, input logic r, input logic w,
                        input logic [3:0] region, input logic [7:0] o, input logic [15:0] d);
        {vs_in, ve_in, ls_in, le_in, filt_done} = s;
        cfg_sel = r | w; cfg_rd = r; cfg_wr = w;
        cfg_addr = {region, o}; cfg_wdata = d;
        @(negedge clk);
        {vs_in, ve_in, ls_in, le_in, filt_done} = 5'b0;
        cfg_sel = 0; cfg_rd = 0; cfg_wr = 0;
    endtask

    task automatic clear_all();
        tick(5'b0, 0, 1, 4'd15, 8'd0, 16'h00FF);
    endtask

    localparam logic [4:0] S_VS = 5'b10000, S_VE = 5'b01000, S_LS = 5'b00100,
                           S_LE = 5'b00010, S_DN = 5'b00001, S_NO = 5'b00000;

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 status after reset", err_status, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);

        // R12: nothing is open outside a frame
        for (int r = 0; r < 8; r++) tick(S_NO, 0, 1, 4'(r), 8'd1, 16'h0);
        chk("R12 no window before frame", err_status, 8'h00);

        tick(S_VS, 0, 0, 4'd0, 8'd0, 16'h0);
        tick(S_NO, 1, 0, 4'd0, 8'd3, 16'h0);
        chk("R2 read in frame outside line", err_status, 8'h00);
        tick(S_NO, 0, 1, 4'd0, 8'd3, 16'h0);
        chk("R2 write in frame", err_status, 8'h01);
        chk("R11 irq with full mask", {7'b0, irq}, 8'h01);
        tick(S_NO, 0, 1, 4'd15, 8'd0, 16'h0000);
        chk("R10 write zero keeps bit", err_status, 8'h01);
        tick(S_NO, 0, 1, 4'd15, 8'd0, 16'h0001);
        chk("R10 write one clears", err_status, 8'h00);

        tick(S_NO, 1, 0, 4'd1, 8'd9, 16'h0);
        chk("R3 table read in frame", err_status, 8'h02);
        clear_all();

        tick(S_LS, 1, 0, 4'd0, 8'd5, 16'h0);
        chk("R2 read in line start cycle", err_status, 8'h01);
        clear_all();
        tick(S_NO, 1, 0, 4'd5, 8'd0, 16'h0);
        chk("R7 color disabled", err_status, 8'h00);
        color_lut_en = 1; contrast_lut_en = 1;
        tick(S_NO, 0, 1, 4'd5, 8'd0, 16'h0);
        chk("R7 color enabled", err_status, 8'h20);
        tick(S_NO, 1, 0, 4'd6, 8'd0, 16'h0);
        chk("R7 contrast enabled", err_status, 8'h60);
        clear_all();
        tick(S_LE, 1, 0, 4'd6, 8'd0, 16'h0);
        chk("R12 line-end cycle still open", err_status, 8'h40);
        clear_all();
        tick(S_NO, 1, 0, 4'd6, 8'd0, 16'h0);
        chk("R7 after line end", err_status, 8'h00);
        color_lut_en = 0; contrast_lut_en = 0;

        tick(S_NO, 1, 0, 4'd3, 8'd0, 16'h0);
        chk("R5 register read ignored", err_status, 8'h00);
        tick(S_NO, 0, 1, 4'd3, 8'd0, 16'h0);
        chk("R5 register write in window", err_status, 8'h08);
        tick(S_DN, 1, 0, 4'd4, 8'd0, 16'h0);
        chk("R6 stats read at done cycle", err_status, 8'h18);
        clear_all();
        tick(S_NO, 0, 1, 4'd4, 8'd0, 16'h0);
        tick(S_NO, 0, 1, 4'd3, 8'd0, 16'h0);
        chk("R6 R5 after filter done", err_status, 8'h00);

        // R9: quiet regions inside frame and line
        tick(S_LS, 0, 0, 4'd0, 8'd0, 16'h0);
        for (int r = 8; r < 15; r++) begin
            tick(S_NO, 1, 0, 4'(r), 8'd0, 16'h0);
            tick(S_NO, 0, 1, 4'(r), 8'd0, 16'h0);
        end
        chk("R9 unmonitored regions", err_status, 8'h00);
        tick(S_LE, 0, 0, 4'd0, 8'd0, 16'h0);

        // R4: lens window spans one cycle past vertical-end
        tick(S_VE, 0, 0, 4'd0, 8'd0, 16'h0);
        tick(S_NO, 1, 0, 4'd2, 8'd0, 16'h0);
        chk("R4 lens access after end", err_status, 8'h04);
        clear_all();
        tick(S_NO, 1, 0, 4'd1, 8'd0, 16'h0);
        tick(S_NO, 1, 0, 4'd2, 8'd0, 16'h0);
        chk("R4 R3 closed windows", err_status, 8'h00);

        // R8: incomplete histogram readout
        tick(S_NO, 1, 0, 4'd7, 8'd0, 16'h0);
        tick(S_VS, 0, 0, 4'd0, 8'd0, 16'h0);
        chk("R8 incomplete read flagged", err_status, 8'h80);
        clear_all();
        tick(S_NO, 1, 0, 4'd7, 8'd0, 16'h0);
        tick(S_NO, 1, 0, 4'd7, 8'd255, 16'h0);
        tick(S_VS, 0, 0, 4'd0, 8'd0, 16'h0);
        chk("R8 complete read quiet", err_status, 8'h00);
        tick(S_NO, 1, 0, 4'd7, 8'd0, 16'h0);
        // R10: set wins against clear in the vertical-start cycle
        tick(S_VS, 0, 1, 4'd15, 8'd0, 16'h0080);
        chk("R10 set wins over clear", err_status, 8'h80);

        // R11: mask gating
        tick(S_NO, 0, 1, 4'd15, 8'd1, 16'h007F);
        chk("R11 masked irq low", {7'b0, irq}, 8'h00);
        tick(S_NO, 0, 1, 4'd15, 8'd1, 16'h0080);
        chk("R11 unmasked irq high", {7'b0, irq}, 8'h01);
        tick(S_VE, 0, 0, 4'd0, 8'd0, 16'h0);
        repeat (3) @(negedge clk);

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule